// File: doc/BRIEF.md
# Pipelined ROM with Load-on-Initialize Word

This block is a read-only lookup store whose result passes through an output register. Each rising clock edge captures the word at the current address into that register. The address can then change freely for the next lookup while the previous result stays on the outputs. The array has `2**ADDR_W` words of `DATA_W` bits. Setting `ADDR_W = 13` and `DATA_W = 8` gives 8192 bytes. The defaults are smaller so that elaboration stays light.

A single control pin, `ctl`, takes one of three roles, chosen by the static parameter `PIN_MODE`:

- **`PIN_ASYNC_OE`**: the pin is an immediate output enable.
- **`PIN_SYNC_OE`**: the pin is a clocked output enable.
- **`PIN_INIT`**: the pin is an active-low initialize. Asserting it loads an extra stored word into the output register at once, without waiting for a clock. It also holds off clocked loads until the pin is released.

The outputs are shown as a data bus plus an enable flag, `dout_oe`, instead of a bidirectional bus. A small write port fills the array and the extra word, so a test environment can program the contents.

Top module: `prom_registered`

## Requirements
- R1: While `rst_n` is low, the output register is cleared and `dout` reads 0. The clocked enable flip-flop resets to enabled, so `dout_oe` is 1 in clocked and initialize modes.
- R2: On each rising edge of `clk`, the output register loads the array word at `addr`. When `dout_oe` is 1, that word appears on `dout` after the edge. In initialize mode this applies only while `ctl` is high.
- R3: Between rising edges, changes on `addr` do not alter `dout`.
- R4: In `PIN_ASYNC_OE` mode, `dout_oe` equals the inverse of `ctl` with no clock involved. Whenever `dout_oe` is 0, `dout` is driven to 0.
- R5: In `PIN_SYNC_OE` mode, `dout_oe` changes only at a rising edge. After the edge it equals the inverse of `ctl` as sampled at that edge.
- R6: In `PIN_INIT` mode, `dout_oe` is always 1.
- R6 (continued): A falling `ctl` loads the stored initialize word into the output register immediately, without a clock edge.
- R7: In `PIN_INIT` mode, clock edges leave the output register unchanged while `ctl` is low. Raising `ctl` does not change the register by itself. The first rising edge after the release loads the array again.
- R8: A write with `wr_en` = 1 at a rising edge works as follows, based on `wr_addr` (width `ADDR_W+1`):
  - If the top bit is 0, the write stores `wr_data` in array word `wr_addr[ADDR_W-1:0]`.
  - If `wr_addr` equals `2**ADDR_W`, the write stores the initialize word.
  - Any other value with the top bit set is ignored.
- R9: After reset the initialize word is all zeros, so an initialize clears the register. Once the word is written to all ones, an initialize presets every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Read address |
| ctl | input | 1 | Dual-role control pin; its meaning is chosen by `PIN_MODE` |
| wr_en | input | 1 | Programming write strobe |
| wr_addr | input | ADDR_W+1 | Programming address; the value `2**ADDR_W` selects the initialize word |
| wr_data | input | DATA_W | Programming data |
| dout | output | DATA_W | Registered read data; reads 0 while disabled |
| dout_oe | output | 1 | Output enable flag; 0 stands for high impedance |

## Verification
The assertions check the following on every clock cycle:

- each edge-to-edge load from the array (R2);
- the enable rule of the selected mode (R4, R5, R6);
- zeroing of the bus while it is disabled (R4);
- the immediate initialize load and the frozen register while initialize is held (R6, R7).

Some behaviours fall between clock edges, and only the bench's timed scenarios can show them:

- that `dout` holds still while the address moves mid-cycle (R3);
- that asynchronous enable and initialize react with no clock edge (R4, R6);
- that releasing initialize alone leaves the register untouched (R7).

The routing of writes, including the ignored addresses (R8), and the clear and preset results (R9) are shown through reads at the ports.

// File: rtl/prom_pkg.sv
package prom_pkg;
    typedef enum logic [1:0] {
        PIN_ASYNC_OE = 2'd0,
        PIN_SYNC_OE  = 2'd1,
        PIN_INIT     = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/prom_store.sv
module prom_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] init_word
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] words;
        logic [DATA_W-1:0]            init;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (!wr_addr[ADDR_W]) begin
                st_d.words[wr_addr[ADDR_W-1:0]] = wr_data;
            end else if (wr_addr[ADDR_W-1:0] == '0) begin
                st_d.init = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.words[rd_addr];
    assign init_word = st_q.init;
endmodule

// File: rtl/prom_oe_ctrl.sv
module prom_oe_ctrl #(
    parameter prom_pkg::pin_mode_e PIN_MODE = prom_pkg::PIN_INIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic oe
);
    generate
        if (PIN_MODE == prom_pkg::PIN_SYNC_OE) begin : g_sync
            logic en_d, en_q;
            always_comb en_d = ~pin;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) en_q <= 1'b1;
                else        en_q <= en_d;
            end
            assign oe = en_q;
        end else if (PIN_MODE == prom_pkg::PIN_ASYNC_OE) begin : g_async
            assign oe = ~pin;
        end else begin : g_init
            assign oe = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/prom_pipe_reg.sv
module prom_pipe_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DATA_W-1:0] init_word,
    output logic [DATA_W-1:0] q
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d.data = load_data;
    end

    // Reset wins; a low init_n loads the extra word and, being level-checked
    // at every clock edge, keeps the clocked path blocked while held.
    always_ff @(posedge clk or negedge rst_n or negedge init_n) begin
        if (!rst_n)       pipe_q.data <= '0;
        else if (!init_n) pipe_q.data <= init_word;
        else              pipe_q <= pipe_d;
    end

    assign q = pipe_q.data;
endmodule

// File: rtl/prom_registered.sv
module prom_registered #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter prom_pkg::pin_mode_e PIN_MODE = prom_pkg::PIN_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctl,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] init_word;
    logic [DATA_W-1:0] pipe_q;
    logic              init_n;
    logic              oe;

    generate
        if (PIN_MODE == prom_pkg::PIN_INIT) begin : g_init_pin
            assign init_n = ctl;
        end else begin : g_no_init
            assign init_n = 1'b1;
        end
    endgenerate

    prom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (addr),
        .rd_data   (rd_data),
        .init_word (init_word)
    );

    prom_pipe_reg #(.DATA_W(DATA_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_n    (init_n),
        .load_data (rd_data),
        .init_word (init_word),
        .q         (pipe_q)
    );

    prom_oe_ctrl #(.PIN_MODE(PIN_MODE)) u_oe (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ctl),
        .oe    (oe)
    );

    assign dout_oe = oe;
    assign dout    = oe ? pipe_q : '0;
endmodule

// File: rtl/prom_registered_chk.sv
module prom_registered_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter prom_pkg::pin_mode_e PIN_MODE = prom_pkg::PIN_INIT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic [DATA_W-1:0] pipe_q,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] init_word
);
    localparam bit IS_INIT  = (PIN_MODE == prom_pkg::PIN_INIT);
    localparam bit IS_SYNC  = (PIN_MODE == prom_pkg::PIN_SYNC_OE);
    localparam bit IS_ASYNC = (PIN_MODE == prom_pkg::PIN_ASYNC_OE);

    // R2
    edge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_INIT || ctl) |=> ((IS_INIT && !ctl) || pipe_q == $past(rd_data)));

    // R4
    async_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        IS_ASYNC |-> (dout_oe == !ctl));

    // R4
    off_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    // R5
    sync_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        IS_SYNC |=> (dout_oe == !$past(ctl)));

    // R6
    init_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        IS_INIT |-> dout_oe);

    // R6
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_INIT && $past(rst_n) && $fell(ctl)) |-> (pipe_q == init_word));

    // R7
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_INIT && $past(rst_n) && !ctl && !$past(ctl)) |-> $stable(pipe_q));
endmodule

bind prom_registered prom_registered_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_MODE(PIN_MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .pipe_q    (pipe_q),
    .rd_data   (rd_data),
    .init_word (init_word)
);

// File: tb/prom_registered_tb.sv
`timescale 1ns/1ps
module prom_registered_tb;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ctl_a, ctl_s, ctl_i;
    logic          wr_en;
    logic [AW:0]   wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] dout_a, dout_s, dout_i;
    logic          oe_a, oe_s, oe_i;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;

    prom_registered #(.ADDR_W(AW), .DATA_W(DW), .PIN_MODE(prom_pkg::PIN_INIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout_i), .dout_oe(oe_i));

    prom_registered #(.ADDR_W(AW), .DATA_W(DW), .PIN_MODE(prom_pkg::PIN_ASYNC_OE)) u_dut_async (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_a), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout_a), .dout_oe(oe_a));

    prom_registered #(.ADDR_W(AW), .DATA_W(DW), .PIN_MODE(prom_pkg::PIN_SYNC_OE)) u_dut_sync (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_s), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout_s), .dout_oe(oe_s));

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 37 + 11);
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read one word and check that a mid-cycle address change has no effect.
    task automatic rd(int a);
        @(negedge clk);
        addr = AW'(a);
        @(posedge clk); #1;
        chk("R2 init-mode read", dout_i, pat(a));
        chk("R2 async-mode read", dout_a, pat(a));
        chk("R2 sync-mode read", dout_s, pat(a));
        addr = ~AW'(a);
        #1;
        chk("R3 hold on address change", dout_i, pat(a));
        chk("R3 hold on address change", dout_s, pat(a));
    endtask

    // Initialize pulse: immediate load, blocked clock, quiet release.
    task automatic init_pulse(logic [DW-1:0] exp, int a);
        @(posedge clk); #1;
        ctl_i = 1'b0;
        #1;
        chk("R6 immediate init load", dout_i, exp);
        chk("R6 enable stays on", {7'd0, oe_i}, 8'd1);
        @(negedge clk);
        addr = AW'(a);
        @(posedge clk); #1;
        chk("R7 clock blocked", dout_i, exp);
        @(posedge clk); #1;
        ctl_i = 1'b1;
        #1;
        chk("R7 release without clock", dout_i, exp);
        @(posedge clk); #1;
        chk("R7 load resumes", dout_i, pat(a));
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; ctl_a = 1'b0; ctl_s = 1'b0; ctl_i = 1'b1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        #3;
        chk("R1 reset init dout", dout_i, 8'd0);
        chk("R1 reset async dout", dout_a, 8'd0);
        chk("R1 reset sync dout", dout_s, 8'd0);
        chk("R1 reset sync oe", {7'd0, oe_s}, 8'd1);
        chk("R1 reset init oe", {7'd0, oe_i}, 8'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: fill the whole array
        for (int a = 0; a < DEPTH; a++) wr((AW+1)'(a), pat(a));
        for (int a = 0; a < DEPTH; a++) rd(a);

        // R8: out-of-range address with top bit set is ignored
        wr((AW+1)'(100), 8'hAA);
        rd(36);

        // R4: asynchronous enable
        rd(10);
        ctl_a = 1'b1;
        #1;
        chk("R4 async disable oe", {7'd0, oe_a}, 8'd0);
        chk("R4 async disabled bus", dout_a, 8'd0);
        ctl_a = 1'b0;
        #1;
        chk("R4 async enable oe", {7'd0, oe_a}, 8'd1);
        chk("R4 async data back", dout_a, pat(10));

        // R5: clocked enable
        @(negedge clk);
        addr = AW'(10);
        ctl_s = 1'b1;
        #1;
        chk("R5 no change before edge", {7'd0, oe_s}, 8'd1);
        @(posedge clk); #1;
        chk("R5 disabled after edge", {7'd0, oe_s}, 8'd0);
        chk("R5 disabled bus", dout_s, 8'd0);
        @(negedge clk);
        ctl_s = 1'b0;
        #1;
        chk("R5 still off before edge", {7'd0, oe_s}, 8'd0);
        @(posedge clk); #1;
        chk("R5 enabled after edge", {7'd0, oe_s}, 8'd1);
        chk("R5 data after enable", dout_s, pat(10));

        // R9: unprogrammed word clears (also confirms R8 ignored write)
        rd(10);
        init_pulse(8'h00, 20);
        // R9: all-ones word presets
        wr((AW+1)'(DEPTH), 8'hFF);
        init_pulse(8'hFF, 33);
        // R8: initialize word written at address DEPTH
        wr((AW+1)'(DEPTH), 8'h5A);
        init_pulse(8'h5A, 47);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule